// File: doc/BRIEF.md
# Root-Nyquist pulse-shaping interpolator

This block band-limits two symbol streams, in-phase and quadrature, before they go to a pair of converters. Each symbol enters as a small signed integer on a one-cycle strobe. For each symbol the block produces eight filtered samples per channel. The filter is a square-root raised-cosine response with roll-off 0.5. Its 3 dB edge sits at half the symbol rate: 96 kHz for a 192 ksym/s stream, which carries 384 kbit/s at two bits per symbol. The block runs from the 19.2 MHz master clock, so each symbol has a budget of 100 cycles.

The 64-tap response spans eight symbols and is split into eight phases of eight taps each. A single serial multiply-accumulate per channel walks one phase at a time. Both channels share one controller and one constant coefficient table. A three-state machine sequences the work:
- `ST_IDLE` waits for a strobe. Transition *accept*: strobe seen, so the delay line shifts and the machine goes to `ST_MAC`.
- `ST_MAC` adds one tap per cycle. Transition *phase done*: after the eighth tap, go to `ST_EMIT`.
- `ST_EMIT` rounds and saturates the sum and presents it as an output. Transition *next phase*: go back to `ST_MAC` for phases 0 to 6. Transition *burst done*: after phase 7, return to `ST_IDLE`.

One burst therefore takes 72 cycles.

Top module: `rrc_interp`

## Requirements
- R1: While reset is low, and after it until the first strobe, `smp_valid` is 0 and `smp_i` and `smp_q` are 0. The symbol history is cleared to zeros.
- R2: A strobe sampled in `ST_IDLE` takes `sym_i` and `sym_q` in at that edge (edge 0). Eight one-cycle `smp_valid` pulses follow, for phases p = 0..7. The pulse for phase p is high in the cycle after edge 9(p+1). A new strobe is accepted from edge 73 on.
- R3: The output of phase p for channel c is S(sum over s=0..7 of x_c[j-s] * h[p+8s]), where x_c[j] is the newest accepted symbol. The taps h[n], n=0..63, are square-root raised-cosine samples with roll-off 0.5 taken at t=(n-31.5)/8 symbol periods, scaled by 1600 and rounded to integers. They are symmetric, h[n]=h[63-n], with h[31]=h[32]=1802.
- R4: S rounds by adding 16 and shifting arithmetically right by 5 bits.
- R5: S clips to the 10-bit signed range [-512, 511].
- R6: Between pulses `smp_i` and `smp_q` hold their last value, and `smp_valid` is never high on two cycles in a row.
- R7: A strobe that arrives while a burst is in progress (`ST_MAC` or `ST_EMIT`) is ignored. It does not enter the symbol history and it does not disturb the running burst.
- R8: A single nonzero symbol a, followed by zeros, produces S(a*h[n]) for n=0..63 in order over eight bursts.
- R9: A constant input c produces, from the eighth burst on, the steady value S(c * sum over s of h[p+8s]) for phase p.
- R10: After eight zero symbols every output is exactly 0.
- R11: The in-phase and quadrature channels use the same taps and do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_stb | input | 1 | One-cycle symbol strobe |
| sym_i | input | IN_W (4) | In-phase symbol, signed |
| sym_q | input | IN_W (4) | Quadrature symbol, signed |
| smp_valid | output | 1 | Output sample pulse |
| smp_i | output | OUT_W (10) | Filtered in-phase sample, signed |
| smp_q | output | OUT_W (10) | Filtered quadrature sample, signed |

## Verification
Each accepted strobe makes the eight phase results due 9, 18, and so on up to 72 cycles after the sampling edge. After the last one no pulse is due until the next strobe. The bench sends a symbol and then walks cycle by cycle to the next strobe. On every cycle it samples half a period after the edge. It expects a pulse with the model value only on those multiples of nine, and a held value with no pulse on every other cycle. Stray strobes are placed mid-burst, and one run uses the minimum 73-cycle spacing. This shows that ignored strobes leave the expected timing and values untouched.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    localparam int OSR    = 8;
    localparam int SPAN   = 8;
    localparam int COEF_W = 12;
    localparam int TAP_W  = $clog2(SPAN);
    localparam int PH_W   = $clog2(OSR);
    localparam int IDX_W  = TAP_W + PH_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_EMIT = 2'd2
    } rrc_state_e;

    // Symmetric table: fold the 64-tap index onto the 32 unique values,
    // entry 0 being the tap nearest the centre of the response.
    function automatic logic signed [COEF_W-1:0] rrc_coef(input logic [IDX_W-1:0] idx);
        logic [IDX_W-2:0] f;
        f = idx[IDX_W-1] ? idx[IDX_W-2:0] : ~idx[IDX_W-2:0];
        unique case (f)
            5'd0:  return  12'sd1802;
            5'd1:  return  12'sd1669;
            5'd2:  return  12'sd1425;
            5'd3:  return  12'sd1102;
            5'd4:  return  12'sd747;
            5'd5:  return  12'sd405;
            5'd6:  return  12'sd114;
            5'd7:  return -12'sd97;
            5'd8:  return -12'sd220;
            5'd9:  return -12'sd258;
            5'd10: return -12'sd230;
            5'd11: return -12'sd161;
            5'd12: return -12'sd78;
            5'd13: return -12'sd4;
            5'd14: return  12'sd47;
            5'd15: return  12'sd68;
            5'd16: return  12'sd62;
            5'd17: return  12'sd39;
            5'd18: return  12'sd10;
            5'd19: return -12'sd15;
            5'd20: return -12'sd29;
            5'd21: return -12'sd30;
            5'd22: return -12'sd20;
            5'd23: return -12'sd4;
            5'd24: return  12'sd13;
            5'd25: return  12'sd24;
            5'd26: return  12'sd27;
            5'd27: return  12'sd22;
            5'd28: return  12'sd11;
            5'd29: return -12'sd1;
            5'd30: return -12'sd11;
            5'd31: return -12'sd16;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/rrc_ctrl.sv
module rrc_ctrl
    import rrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_stb,
    output logic             shift_en,
    output logic             acc_en,
    output logic             emit,
    output logic [TAP_W-1:0] tap,
    output logic [PH_W-1:0]  phase
);

    rrc_state_e state, nstate;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next state and strobes
    always_comb begin
        nstate   = state;
        shift_en = 1'b0;
        acc_en   = 1'b0;
        emit     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sym_stb) begin
                    shift_en = 1'b1;
                    nstate   = ST_MAC;
                end
            end
            ST_MAC: begin
                acc_en = 1'b1;
                if (tap == TAP_W'(SPAN-1)) nstate = ST_EMIT;
            end
            ST_EMIT: begin
                emit   = 1'b1;
                nstate = (phase == PH_W'(OSR-1)) ? ST_IDLE : ST_MAC;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Tap and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap   <= '0;
            phase <= '0;
        end else begin
            if (shift_en) begin
                tap   <= '0;
                phase <= '0;
            end
            if (acc_en)
                tap <= (tap == TAP_W'(SPAN-1)) ? '0 : tap + TAP_W'(1);
            if (emit)
                phase <= (phase == PH_W'(OSR-1)) ? '0 : phase + PH_W'(1);
        end
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (state == ST_MAC && tap == '0 && phase == '0));

    assert_burst_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && phase == PH_W'(OSR-1)) |=> (state == ST_IDLE));

    assert_pulse_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        emit |=> !emit);

    assert_tap_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAC && tap != TAP_W'(SPAN-1))
            |=> (state == ST_MAC && tap == $past(tap) + TAP_W'(1)));

endmodule

// File: rtl/rrc_mac.sv
module rrc_mac
    import rrc_pkg::*;
#(
    parameter int IN_W  = 4,
    parameter int OUT_W = 10,
    parameter int SHIFT = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic                     acc_en,
    input  logic                     emit,
    input  logic signed [IN_W-1:0]   sym,
    input  logic [TAP_W-1:0]         tap,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [OUT_W-1:0]  y
);

    localparam int PROD_W = IN_W + COEF_W;
    localparam int ACC_W  = PROD_W + TAP_W;
    localparam logic signed [ACC_W-1:0] RND_K  = ACC_W'(2**(SHIFT-1));
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2**(OUT_W-1) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    logic signed [IN_W-1:0]   hist [SPAN];
    logic signed [ACC_W-1:0]  acc;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  rnd, shf;
    logic signed [OUT_W-1:0]  y_nxt;

    assign prod = hist[tap] * coef;

    always_comb begin
        rnd = acc + RND_K;
        shf = rnd >>> SHIFT;
        if (shf > SAT_HI)      y_nxt = SAT_HI[OUT_W-1:0];
        else if (shf < SAT_LO) y_nxt = SAT_LO[OUT_W-1:0];
        else                   y_nxt = shf[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SPAN; s++) hist[s] <= '0;
            acc <= '0;
            y   <= '0;
        end else begin
            if (shift_en) begin
                hist[0] <= sym;
                for (int s = 1; s < SPAN; s++) hist[s] <= hist[s-1];
            end
            if (shift_en || emit) acc <= '0;
            else if (acc_en)      acc <= acc + ACC_W'(prod);
            if (emit) y <= y_nxt;
        end
    end

    assert_acc_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en || emit) |=> (acc == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !emit |=> $stable(y));

endmodule

// File: rtl/rrc_interp.sv
module rrc_interp
    import rrc_pkg::*;
#(
    parameter int IN_W  = 4,
    parameter int OUT_W = 10,
    parameter int SHIFT = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_stb,
    input  logic signed [IN_W-1:0]  sym_i,
    input  logic signed [IN_W-1:0]  sym_q,
    output logic                    smp_valid,
    output logic signed [OUT_W-1:0] smp_i,
    output logic signed [OUT_W-1:0] smp_q
);

    localparam int NCH = 2;

    logic                     shift_en, acc_en, emit;
    logic [TAP_W-1:0]         tap;
    logic [PH_W-1:0]          phase;
    logic signed [COEF_W-1:0] coef;
    logic signed [IN_W-1:0]   ch_in  [NCH];
    logic signed [OUT_W-1:0]  ch_out [NCH];

    assign ch_in[0] = sym_i;
    assign ch_in[1] = sym_q;
    assign coef     = rrc_coef({tap, phase});

    rrc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_stb  (sym_stb),
        .shift_en (shift_en),
        .acc_en   (acc_en),
        .emit     (emit),
        .tap      (tap),
        .phase    (phase)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rrc_mac #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_mac (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .acc_en   (acc_en),
            .emit     (emit),
            .sym      (ch_in[c]),
            .tap      (tap),
            .coef     (coef),
            .y        (ch_out[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_valid <= 1'b0;
        else        smp_valid <= emit;
    end

    assign smp_i = ch_out[0];
    assign smp_q = ch_out[1];

endmodule

// File: tb/rrc_interp_tb.sv
`timescale 1ns/1ps
module rrc_interp_tb;

    localparam int IN_W  = 4;
    localparam int OUT_W = 10;
    localparam int SHIFT = 5;
    localparam int OSR   = 8;
    localparam int SPAN  = 8;
    localparam int GAP   = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_stb = 1'b0;
    logic signed [IN_W-1:0] sym_i = '0, sym_q = '0;
    logic smp_valid;
    logic signed [OUT_W-1:0] smp_i, smp_q;

    int checks = 0, errors = 0;
    bit done = 0;
    int hb[32] = '{1802, 1669, 1425, 1102, 747, 405, 114, -97,
                   -220, -258, -230, -161, -78, -4, 47, 68,
                   62, 39, 10, -15, -29, -30, -20, -4,
                   13, 24, 27, 22, 11, -1, -11, -16};
    int li[SPAN], lq[SPAN];
    int exp_i[OSR], exp_q[OSR], got_i[OSR], got_q[OSR];
    int last_i = 0, last_q = 0;

    always #2.5 clk = ~clk;

    rrc_interp #(.IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_dut (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sym_i(sym_i), .sym_q(sym_q),
        .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q));

    function automatic int tap_h(int n);
        return (n >= 32) ? hb[n-32] : hb[31-n];
    endfunction

    function automatic int scale(int a);
        int r, hi;
        hi = (1 << (OUT_W-1)) - 1;
        r = (a + (1 << (SHIFT-1))) >>> SHIFT;
        if (r > hi) r = hi;
        if (r < -hi-1) r = -hi-1;
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic send(input int xi, input int xq, input string tag, input int stray, input int gap);
        for (int s = SPAN-1; s > 0; s--) begin li[s] = li[s-1]; lq[s] = lq[s-1]; end
        li[0] = xi; lq[0] = xq;
        for (int p = 0; p < OSR; p++) begin
            int ai = 0, aq = 0;
            for (int s = 0; s < SPAN; s++) begin
                ai += li[s] * tap_h(p + OSR*s);
                aq += lq[s] * tap_h(p + OSR*s);
            end
            exp_i[p] = scale(ai);
            exp_q[p] = scale(aq);
        end
        sym_i = IN_W'(xi); sym_q = IN_W'(xq); sym_stb = 1'b1;
        @(negedge clk);
        sym_stb = 1'b0;
        chk(tag, int'(smp_valid), 0, "R2 no pulse at accept edge");
        for (int c = 1; c < gap; c++) begin
            if (stray != 0 && c == stray) begin
                sym_stb = 1'b1; sym_i = IN_W'(5); sym_q = IN_W'(-6);
            end
            @(negedge clk);
            sym_stb = 1'b0;
            if (c % 9 == 0 && c / 9 >= 1 && c / 9 <= OSR) begin
                int p = c / 9 - 1;
                chk(tag, int'(smp_valid), 1, "R2 pulse due");
                chk(tag, int'(smp_i), exp_i[p], "R3 I sample");
                chk(tag, int'(smp_q), exp_q[p], "R11 Q sample");
                got_i[p] = int'(smp_i); got_q[p] = int'(smp_q);
                last_i = exp_i[p]; last_q = exp_q[p];
            end else begin
                chk(tag, int'(smp_valid), 0, "R6 no pulse");
                chk(tag, int'(smp_i), last_i, "R6 I hold");
                chk(tag, int'(smp_q), last_q, "R6 Q hold");
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        int sp[8] = '{-8, -8, 7, -8, 7, -8, 7, 7};
        int sq[8] = '{7, 7, -8, 7, -8, 7, -8, -8};
        for (int s = 0; s < SPAN; s++) begin li[s] = 0; lq[s] = 0; end
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", int'(smp_valid), 0, "valid in reset");
        chk("R1", int'(smp_i), 0, "I in reset");
        chk("R1", int'(smp_q), 0, "Q in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", int'(smp_valid), 0, "valid idle after reset");
        chk("R1", int'(smp_i), 0, "I idle after reset");

        // R8: impulse response on both channels
        send(7, -8, "R8", 0, GAP);
        for (int k = 0; k < 7; k++) send(0, 0, "R8", 0, GAP);

        // R10: history fully flushed
        send(0, 0, "R10", 0, GAP);
        for (int p = 0; p < OSR; p++) begin
            chk("R10", got_i[p], 0, "I after flush");
            chk("R10", got_q[p], 0, "Q after flush");
        end

        // R9: constant input
        for (int k = 0; k < 10; k++) send(3, -2, "R9", 0, GAP);

        // R5: clipping on I, just inside on Q
        for (int k = 0; k < 8; k++) send(sp[k], sq[k], "R5", 0, GAP);
        chk("R5", got_i[0], -512, "I phase 0 clipped");
        chk("R5", got_q[0], 510, "Q phase 0 inside range");

        // R3 R4 R11: mixed data, tight spacing and stray strobes (R7)
        seed = 12345;
        for (int k = 0; k < 16; k++) begin
            int xi, xq;
            seed = seed * 1103515245 + 12345;
            xi = ((seed >>> 8) & 15) - 8;
            xq = ((seed >>> 16) & 15) - 8;
            if (k % 4 == 1)      send(xi, xq, "R7", 30, GAP);
            else if (k % 4 == 2) send(xi, xq, "R2", 0, 73);
            else                 send(xi, xq, "R4", 0, GAP);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule